// File: doc/BRIEF.md
# I2C Register-Access Slave Front End

This block is the serial front end of a 16-bit port expander. It samples the two-wire bus lines on a fast system clock and filters out short spikes on each line. It then finds the bus conditions (START, repeated START, STOP) and runs the byte-level slave protocol. The block answers to one 7-bit address. That address is built from three strap inputs, so 32 different values are possible.

After a matching write address, the next byte loads a register pointer. Each later data byte becomes a one-cycle write strobe to the register bank, at the pointer's location. After a matching read address, which normally follows a repeated START, each byte sent to the master is fetched with a one-cycle read strobe. The pointer steps by one after every data byte and wraps after the last register. The block drives SDA only through an open-drain pull-low enable, for ACK bits and read data. The register bank itself sits outside the block.

Top module: `i2c_regif_slave`

## Requirements
- R1: While reset is held and right after it is released, `sda_oe_o`, `reg_wr_o` and `reg_rd_o` are low and `reg_addr_o` is 0.
- R2: Each strap input is a 2-bit code (00 ground, 01 supply, 10 tied to SCL, 11 tied to SDA). The 7-bit slave address is {0, G, a2[0], a1[0], a0[0]}. G is 100 when neither a1 nor a0 is tied to a bus line, 101 when only a0 is, 010 when only a1 is, and 011 when both are. An address byte that matches (address in bits 7:1, direction in bit 0) is ACKed by pulling SDA low during the ninth clock.
- R3: An address that does not match is NACKed. All further bytes are then ignored (no ACK, no strobe) until the next START or STOP.
- R4: The byte after a matching write address loads the pointer, and `reg_addr_o` then shows it. A value of NUM_REGS (22) or above loads 0.
- R5: Each complete write data byte gives exactly one single-cycle `reg_wr_o` pulse, with `reg_wdata_o` equal to the byte and `reg_addr_o` equal to the pointer. The byte is ACKed.
- R6: The pointer steps by one in the cycle after every write or read strobe, and wraps from 21 (0x15) to 0.
- R7: After a matching address with direction bit 1, the block sends bytes MSB first. Each byte is the value of `reg_rdata_i` taken in the cycle of a single-cycle `reg_rd_o` pulse. A master ACK fetches the next byte; a master NACK ends the read with no further strobe.
- R8: Pulses of up to 10 system clocks (50 ns at 200 MHz) on SCL or SDA have no effect on the transfer.
- R9: A START or STOP before the eighth bit of a byte is complete aborts that byte. No write strobe occurs and the pointer is unchanged.
- R10: `sda_oe_o` rises only while the filtered SCL is low, and is never asserted outside an ACK slot or a read data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| a2_strap_i | input | 2 | Strap code for the upper address select |
| a1_strap_i | input | 2 | Strap code for the middle address select |
| a0_strap_i | input | 2 | Strap code for the lower address select |
| reg_addr_o | output | 5 | Register pointer |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data byte |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, valid in the cycle of `reg_rd_o` |

## Verification
The assertions assume the following about the inputs:
- The straps do not change outside reset.
- The SCL low time is far longer than the filter delay, so every change of the SDA enable lands while the filtered clock is low.
- The master moves SDA while SCL is high only to signal START or STOP.

The stimulus keeps to these limits. It changes straps only while reset is held, uses bit slots of 160 clocks, and keeps every injected spike at 10 clocks, placed well inside an SCL high phase.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;
  typedef enum logic [1:0] {
    STRAP_GND = 2'b00,
    STRAP_VCC = 2'b01,
    STRAP_SCL = 2'b10,
    STRAP_SDA = 2'b11
  } strap_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_DATA
  } kind_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int LEN     = 12,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  // output follows only after LEN consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      q_o    <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], d_i};
      if (sync_q[1] == q_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(LEN - 1)) begin
        q_o   <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_strap_addr.sv
module i2c_strap_addr (
  input  logic [1:0] a2_i,
  input  logic [1:0] a1_i,
  input  logic [1:0] a0_i,
  output logic [6:0] addr_o
);
  logic [2:0] grp;

  // bit 1 of a code marks a strap tied to a bus line
  always_comb begin
    unique case ({a1_i[1], a0_i[1]})
      2'b00:   grp = 3'b100;
      2'b01:   grp = 3'b101;
      2'b10:   grp = 3'b010;
      default: grp = 3'b011;
    endcase
    addr_o = {1'b0, grp, a2_i[0], a1_i[0], a0_i[0]};
  end
endmodule

// File: rtl/i2c_regif_slave.sv
module i2c_regif_slave
  import i2c_regif_pkg::*;
#(
  parameter int FILT_CYCLES = 12,
  parameter int NUM_REGS    = 22,
  localparam int AW         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [1:0]    a2_strap_i,
  input  logic [1:0]    a1_strap_i,
  input  logic [1:0]    a0_strap_i,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_wr_o,
  output logic [7:0]    reg_wdata_o,
  output logic          reg_rd_o,
  input  logic [7:0]    reg_rdata_i
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  logic [1:0] raw, filt;
  logic       scl_filt, sda_filt;
  logic       start, stop, rise, fall;
  logic [6:0] own_addr;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_glitch_filter #(.LEN(FILT_CYCLES), .RST_VAL(1'b1)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (filt[g])
    );
  end

  assign scl_filt = filt[0];
  assign sda_filt = filt[1];

  i2c_bus_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_filt),
    .sda_i  (sda_filt),
    .start_o(start),
    .stop_o (stop),
    .rise_o (rise),
    .fall_o (fall)
  );

  i2c_strap_addr u_addr (
    .a2_i  (a2_strap_i),
    .a1_i  (a1_strap_i),
    .a0_i  (a0_strap_i),
    .addr_o(own_addr)
  );

  state_e        state;
  kind_e         kind;
  logic [3:0]    bit_cnt;
  logic [7:0]    rx_sh, tx_sh;
  logic          rnw, mack;
  logic [AW-1:0] ptr;

  assign reg_addr_o = ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      kind        <= K_ADDR;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      rnw         <= 1'b0;
      mack        <= 1'b0;
      ptr         <= '0;
      sda_oe_o    <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      reg_wr_o <= 1'b0;
      reg_rd_o <= 1'b0;
      if (reg_wr_o || reg_rd_o) begin
        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
      if (reg_rd_o) begin
        tx_sh <= reg_rdata_i;
        if (state == ST_TX) sda_oe_o <= ~reg_rdata_i[7];
      end

      if (start) begin
        state    <= ST_RX;
        kind     <= K_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (rise && bit_cnt < 4'd8) begin
              rx_sh   <= {rx_sh[6:0], sda_filt};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (fall && bit_cnt == 4'd8) begin
              unique case (kind)
                K_ADDR: begin
                  if (rx_sh[7:1] == own_addr) begin
                    sda_oe_o <= 1'b1;
                    rnw      <= rx_sh[0];
                    reg_rd_o <= rx_sh[0];
                    state    <= ST_RX_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                K_CMD: begin
                  ptr      <= (int'(rx_sh) < NUM_REGS) ? rx_sh[AW-1:0] : '0;
                  sda_oe_o <= 1'b1;
                  state    <= ST_RX_ACK;
                end
                default: begin
                  reg_wr_o    <= 1'b1;
                  reg_wdata_o <= rx_sh;
                  sda_oe_o    <= 1'b1;
                  state       <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (fall) begin
              bit_cnt <= '0;
              if (kind == K_ADDR && rnw) begin
                state    <= ST_TX;
                sda_oe_o <= ~tx_sh[7];
              end else begin
                state    <= ST_RX;
                sda_oe_o <= 1'b0;
                kind     <= (kind == K_ADDR) ? K_CMD : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (rise) bit_cnt <= bit_cnt + 1'b1;
            if (fall && bit_cnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              state    <= ST_TX_ACK;
            end else if (fall && bit_cnt != 4'd0) begin
              tx_sh    <= {tx_sh[6:0], 1'b0};
              sda_oe_o <= ~tx_sh[6];
            end
          end
          ST_TX_ACK: begin
            if (rise) mack <= ~sda_filt;
            if (fall) begin
              if (mack) begin
                reg_rd_o <= 1'b1;
                state    <= ST_TX;
                bit_cnt  <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regif_slave_chk.sv
module i2c_regif_slave_chk #(
  parameter int NUM_REGS = 22,
  localparam int AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_f_i,
  input logic          sda_oe_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [AW-1:0] addr_i
);
  logic [AW-1:0] nxt;
  always_comb nxt = (addr_i == AW'(NUM_REGS - 1)) ? '0 : addr_i + 1'b1;

  AST_WR_RD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i)); // R5
  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !wr_i); // R5
  AST_WR_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !$past(scl_f_i)); // R5
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !rd_i); // R7
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(addr_i) < NUM_REGS); // R6
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) |=> addr_i == $past(nxt)); // R6
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !$past(scl_f_i)); // R10
endmodule

bind i2c_regif_slave i2c_regif_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_f_i (scl_filt),
  .sda_oe_i(sda_oe_o),
  .wr_i    (reg_wr_o),
  .rd_i    (reg_rd_o),
  .addr_i  (reg_addr_o)
);

// File: tb/i2c_regif_slave_bench.sv
`timescale 1ns/1ps
module i2c_regif_slave_bench;
  localparam int NREG = 22;
  localparam int Q    = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, scl_sp = 1'b0, sda_sp = 1'b0;
  logic [1:0] a2 = 2'b00, a1 = 2'b00, a0 = 2'b00;
  logic sda_oe, wr, rd, sda_line, scl_in, sda_in;
  logic [4:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] bank [NREG];
  logic [7:0] mbank [NREG];
  logic [7:0] wq [$];
  int mptr = 0, wr_cnt = 0, rd_cnt = 0, drive_err = 0;
  int n_chk = 0, n_fail = 0;
  bit may_drive = 1'b0, done = 1'b0;

  assign sda_line = m_sda & ~sda_oe;
  assign scl_in   = m_scl & ~scl_sp;
  assign sda_in   = sda_line & ~sda_sp;
  assign rdata    = (int'(addr) < NREG) ? bank[addr] : 8'h00;

  i2c_regif_slave u_i2c_regif_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_in), .sda_i(sda_in), .sda_oe_o(sda_oe),
    .a2_strap_i(a2), .a1_strap_i(a1), .a0_strap_i(a0),
    .reg_addr_o(addr), .reg_wr_o(wr), .reg_wdata_o(wdata),
    .reg_rd_o(rd), .reg_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (wr) begin bank[addr] <= wdata; wr_cnt <= wr_cnt + 1; end
    if (rd) rd_cnt <= rd_cnt + 1;
  end

  // per-clock model of when the slave may own SDA (R10)
  always @(negedge clk) if (rst_n && !may_drive && sda_oe) drive_err++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0; may_drive = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    w(4); rst_n = 1'b1; w(4);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0;
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(2*Q);
  endtask

  task automatic bit_out(input logic b, input bit spike);
    w(Q); m_sda = b; w(Q); m_scl = 1'b1; w(Q);
    if (spike) begin
      scl_sp = 1'b1; w(10); scl_sp = 1'b0; w(10);
      sda_sp = 1'b1; w(10); sda_sp = 1'b0;
    end
    w(Q); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit keep, input int spk, output bit ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i], i == spk);
    m_sda = 1'b1; may_drive = 1'b1;
    w(2*Q); m_scl = 1'b1; w(Q); ack = !sda_line; w(Q); m_scl = 1'b0;
    if (!keep) begin w(Q); may_drive = 1'b0; end
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    may_drive = 1'b1; m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(2*Q); m_scl = 1'b1; w(Q); b[i] = sda_line; w(Q); m_scl = 1'b0;
    end
    w(Q); may_drive = 1'b0; m_sda = !mack;
    w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0;
  endtask

  function automatic int load_ptr(input logic [7:0] c);
    return (int'(c) < NREG) ? int'(c) : 0;
  endfunction

  // write cmd then every byte of wq, model updated from the requirements
  task automatic do_write(input logic [6:0] sa, input logic [7:0] cmd);
    bit a; int acks = 0; int w0 = wr_cnt;
    i2c_start();
    send_byte({sa, 1'b0}, 0, -1, a); acks += a;
    send_byte(cmd, 0, -1, a); acks += a;
    mptr = load_ptr(cmd);
    foreach (wq[i]) begin
      send_byte(wq[i], 0, -1, a); acks += a;
      mbank[mptr] = wq[i];
      mptr = (mptr == NREG-1) ? 0 : mptr + 1;
    end
    i2c_stop(); w(4);
    chk(acks == wq.size() + 2, "R5 acks on write", acks, wq.size() + 2);
    chk(wr_cnt - w0 == wq.size(), "R5 write strobes", wr_cnt - w0, wq.size());
    chk(int'(addr) == mptr, "R6 pointer after write", addr, mptr);
    for (int i = 0; i < NREG; i++)
      if (bank[i] !== mbank[i]) chk(1'b0, "R5 bank entry", bank[i], mbank[i]);
    chk(1'b1, "R5 bank compare", 0, 0);
  endtask

  task automatic do_read(input logic [6:0] sa, input logic [7:0] cmd, input int n);
    bit a; int acks = 0; int r0 = rd_cnt; logic [7:0] b;
    i2c_start();
    send_byte({sa, 1'b0}, 0, -1, a); acks += a;
    send_byte(cmd, 0, -1, a); acks += a;
    mptr = load_ptr(cmd);
    i2c_start();
    send_byte({sa, 1'b1}, 1, -1, a); acks += a;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n-1, b);
      chk(b == mbank[mptr], "R7 read byte", b, mbank[mptr]);
      mptr = (mptr == NREG-1) ? 0 : mptr + 1;
    end
    i2c_stop(); w(4);
    chk(acks == 3, "R7 acks on read setup", acks, 3);
    chk(rd_cnt - r0 == n, "R7 read strobes", rd_cnt - r0, n);
    chk(int'(addr) == mptr, "R6 pointer after read", addr, mptr);
  endtask

  initial begin
    logic [5:0] cfg [8];
    logic [6:0] exp7 [8];
    bit a; int acks; int w0; logic [7:0] b;
    // strap sets {a2,a1,a0} and their 7-bit addresses from the address map
    cfg[0] = 6'b00_10_00; exp7[0] = 7'h10;
    cfg[1] = 6'b01_11_01; exp7[1] = 7'h17;
    cfg[2] = 6'b00_10_10; exp7[2] = 7'h18;
    cfg[3] = 6'b01_01_01; exp7[3] = 7'h27;
    cfg[4] = 6'b00_00_11; exp7[4] = 7'h29;
    cfg[5] = 6'b01_01_11; exp7[5] = 7'h2F;
    cfg[6] = 6'b01_00_10; exp7[6] = 7'h2C;
    cfg[7] = 6'b00_00_00; exp7[7] = 7'h20;
    for (int i = 0; i < NREG; i++) begin bank[i] = 8'(i*13 + 5); mbank[i] = 8'(i*13 + 5); end

    w(3);
    chk(sda_oe == 0 && wr == 0 && rd == 0, "R1 outputs in reset", {sda_oe, wr, rd}, 0);
    do_reset();
    chk(sda_oe == 0, "R1 sda_oe after reset", sda_oe, 0);
    chk(wr == 0 && rd == 0, "R1 strobes after reset", {wr, rd}, 0);
    chk(addr == 0, "R1 pointer after reset", addr, 0);

    for (int c = 0; c < 8; c++) begin
      {a2, a1, a0} = cfg[c];
      do_reset();
      i2c_start(); send_byte({exp7[c], 1'b0}, 0, -1, a); i2c_stop();
      chk(a == 1, "R2 strap address ACK", a, 1);
      i2c_start(); send_byte({exp7[c] ^ 7'h01, 1'b0}, 0, -1, a); i2c_stop();
      chk(a == 0, "R2 neighbour address NACK", a, 0);
    end

    // all straps at ground: address 0x20
    wq = '{8'hA5, 8'h5A};            do_write(7'h20, 8'h03);
    do_read(7'h20, 8'h03, 2);
    wq = '{8'h11, 8'h22, 8'h33};     do_write(7'h20, 8'h14);
    do_read(7'h20, 8'h15, 2);
    do_read(7'h20, 8'h00, 1);

    // R4: out-of-range command loads 0
    i2c_start(); send_byte(8'h40, 0, -1, a); send_byte(8'h1F, 0, -1, a); i2c_stop(); w(4);
    chk(addr == 0, "R4 oversize command", addr, 0);
    i2c_start(); send_byte(8'h40, 0, -1, a); send_byte(8'h09, 0, -1, a); i2c_stop(); w(4);
    chk(addr == 9, "R4 command loads pointer", addr, 9);

    // R3: wrong address, following bytes ignored
    w0 = wr_cnt; acks = 0;
    i2c_start();
    send_byte(8'h42, 0, -1, a); acks += a;
    send_byte(8'h05, 0, -1, a); acks += a;
    send_byte(8'hEE, 0, -1, a); acks += a;
    i2c_stop(); w(4);
    chk(acks == 0, "R3 no ACK after mismatch", acks, 0);
    chk(wr_cnt == w0, "R3 no write after mismatch", wr_cnt - w0, 0);
    chk(bank[5] == mbank[5], "R3 register untouched", bank[5], mbank[5]);
    chk(addr == 9, "R3 pointer untouched", addr, 9);

    // R8: spikes on both lines inside bit 5 of a data byte
    acks = 0;
    i2c_start();
    send_byte(8'h40, 0, -1, a); acks += a;
    send_byte(8'h06, 0, -1, a); acks += a;
    send_byte(8'hBD, 0, 5, a);  acks += a;
    i2c_stop(); w(4);
    mbank[6] = 8'hBD;
    chk(acks == 3, "R8 acks with spikes", acks, 3);
    chk(bank[6] == 8'hBD, "R8 data with spikes", bank[6], 8'hBD);
    chk(addr == 7, "R8 pointer with spikes", addr, 7);

    // R9: STOP mid-byte
    w0 = wr_cnt;
    i2c_start(); send_byte(8'h40, 0, -1, a); send_byte(8'h07, 0, -1, a);
    bit_out(1, 0); bit_out(0, 0); bit_out(1, 0); bit_out(1, 0);
    i2c_stop(); w(4);
    chk(wr_cnt == w0, "R9 stop abort no strobe", wr_cnt - w0, 0);
    chk(bank[7] == mbank[7], "R9 stop abort register", bank[7], mbank[7]);
    chk(addr == 7, "R9 stop abort pointer", addr, 7);

    // R9: repeated START mid-byte then read of the same register
    i2c_start(); send_byte(8'h40, 0, -1, a); send_byte(8'h08, 0, -1, a);
    bit_out(0, 0); bit_out(1, 0); bit_out(1, 0);
    i2c_start(); send_byte(8'h41, 1, -1, a);
    chk(a == 1, "R9 read after restart ACK", a, 1);
    recv_byte(0, b); i2c_stop(); w(4);
    chk(wr_cnt == w0, "R9 restart abort no strobe", wr_cnt - w0, 0);
    chk(b == mbank[8], "R9 restart abort read", b, mbank[8]);

    chk(drive_err == 0, "R10 SDA driven outside slave slots", drive_err, 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule